// File: doc/BRIEF.md
# Pipeline Activity Idle Detector

This block tells a pipelined processor whether it still has outstanding work. When it reports no work, the processor can be idled or its clock gated. It keeps a one-bit shift buffer that is as deep as the longest latency between any two pipeline stages. It also keeps one active flag for each stage. A single saturating counter sums the marked buffer slots and the active stages. The processor is reported active whenever that counter is non-zero.

Stages pulse a record strobe whenever they send data to another stage. That strobe marks the newest buffer slot. The buffer shifts one slot on every advance strobe, and a mark is retired when it leaves the oldest slot. Stages that have work of their own raise and drop their flag with indexed activate and deactivate requests. A preload port overwrites the counter so that software can hold the processor awake. A debug output flags any disagreement between the counter and the buffer and flag contents.

Top module: `activity_idle_tracker`

## Requirements
- R1: After reset all buffer slots and stage flags are clear, the counter is zero, active_o is low and mismatch_o is low.
- R2: A record strobe marks slot 0. The counter rises by one only if slot 0 was empty. A second strobe before the next advance leaves the counter unchanged.
- R3: Each advance shifts the buffer one slot toward the oldest end. The counter falls by one when a mark leaves the oldest slot, so a mark is retired on the DEPTH-th advance after it was recorded.
- R4: When advance and record fall in the same cycle, the shift happens first and the new mark lands in the cleared slot 0. The counter then rises by one.
- R5: An activate request for an inactive stage sets its flag and raises the counter by one. Activating a stage that is already active changes nothing.
- R6: A deactivate request for an active stage clears its flag and lowers the counter by one. Deactivating a stage that is already inactive changes nothing.
- R7: A request whose stage index is N_STAGES or above is ignored.
- R8: active_o is high exactly when the counter is non-zero.
- R9: A preload overwrites the counter with load_val_i, and this takes priority over any other counter change in that cycle. The buffer and the flags still update normally.
- R10: The counter saturates at 0 and at 2^CNT_W-1 instead of wrapping.
- R11: mismatch_o is high while the counter differs from the number of marked slots plus the number of active flags. Without a preload this cannot happen.
- R12: An activate and a deactivate request aimed at the same stage in the same cycle cancel, leaving that stage and the counter unchanged. Requests aimed at different stages both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| record_i | input | 1 | Record communication this cycle |
| advance_i | input | 1 | Shift the activity buffer |
| act_req_i | input | 1 | Activate request |
| act_idx_i | input | IDX_W | Stage to activate |
| deact_req_i | input | 1 | Deactivate request |
| deact_idx_i | input | IDX_W | Stage to deactivate |
| load_i | input | 1 | Preload the counter |
| load_val_i | input | CNT_W | Preload value |
| active_o | output | 1 | Outstanding work present |
| count_o | output | CNT_W | Counter value |
| stage_flags_o | output | N_STAGES | Per-stage active flags |
| mismatch_o | output | 1 | Counter disagrees with buffer and flags |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a buffer advance and a record strobe. The second pair is an activate and a deactivate request, either on the same stage or on different stages. The bench drives both members of each pair in a single cycle. For the first pair, it follows the two marks through the counter and expects them to retire on two separate advances. For the second pair, it reads the flags and the counter to confirm that same-stage requests cancel and different-stage requests both take effect.

// File: rtl/activity_pkg.sv
package activity_pkg;
  // Saturating counter update: base + up - down, clamped to [0, max_v]
  function automatic int sat_step(int base, int up, int down, int max_v);
    int s;
    s = base + up - down;
    if (s < 0) s = 0;
    else if (s > max_v) s = max_v;
    return s;
  endfunction
endpackage

// File: rtl/activity_shift_buf.sv
module activity_shift_buf #(
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             record_i,
  input  logic             advance_i,
  output logic [DEPTH-1:0] buf_o,
  output logic             inc_o,
  output logic             dec_o
);
  logic [DEPTH-1:0] buf_q, shifted;

  generate
    if (DEPTH == 1) begin : g_single
      assign shifted = advance_i ? 1'b0 : buf_q;
    end else begin : g_multi
      assign shifted = advance_i ? {buf_q[DEPTH-2:0], 1'b0} : buf_q;
    end
  endgenerate

  // shift first, then the new mark lands in slot 0
  assign inc_o = record_i & ~shifted[0];
  assign dec_o = advance_i & buf_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= '0;
    else begin
      buf_q    <= shifted;
      if (record_i) buf_q[0] <= 1'b1;
    end
  end

  assign buf_o = buf_q;
endmodule

// File: rtl/stage_flag_bank.sv
module stage_flag_bank #(
  parameter int N_STAGES = 5,
  parameter int IDX_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_req_i,
  input  logic [IDX_W-1:0]    act_idx_i,
  input  logic                deact_req_i,
  input  logic [IDX_W-1:0]    deact_idx_i,
  output logic [N_STAGES-1:0] flags_o,
  output logic                inc_o,
  output logic                dec_o
);
  logic [N_STAGES-1:0] flags_q, set_v, clr_v;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic hit_a, hit_d;
    assign hit_a    = act_req_i & (act_idx_i == IDX_W'(i));
    assign hit_d    = deact_req_i & (deact_idx_i == IDX_W'(i));
    // opposing requests on one stage cancel
    assign set_v[i] = hit_a & ~hit_d & ~flags_q[i];
    assign clr_v[i] = hit_d & ~hit_a & flags_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q | set_v) & ~clr_v;
  end

  assign inc_o   = |set_v;
  assign dec_o   = |clr_v;
  assign flags_o = flags_q;
endmodule

// File: rtl/activity_counter.sv
module activity_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_buf_i,
  input  logic             dec_buf_i,
  input  logic             inc_stage_i,
  input  logic             dec_stage_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  import activity_pkg::*;
  localparam int MaxVal = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    count_d = CNT_W'(sat_step(int'(count_q),
                              int'(inc_buf_i) + int'(inc_stage_i),
                              int'(dec_buf_i) + int'(dec_stage_i), MaxVal));
    if (load_i) count_d = load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/activity_idle_tracker.sv
module activity_idle_tracker #(
  parameter int DEPTH    = 4,
  parameter int N_STAGES = 5,
  localparam int CNT_W   = $clog2(DEPTH + N_STAGES + 1),
  localparam int IDX_W   = $clog2(N_STAGES) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                record_i,
  input  logic                advance_i,
  input  logic                act_req_i,
  input  logic [IDX_W-1:0]    act_idx_i,
  input  logic                deact_req_i,
  input  logic [IDX_W-1:0]    deact_idx_i,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    load_val_i,
  output logic                active_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [N_STAGES-1:0] stage_flags_o,
  output logic                mismatch_o
);
  logic [DEPTH-1:0] buf_q;
  logic inc_buf, dec_buf, inc_stg, dec_stg;

  activity_shift_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni, .record_i, .advance_i,
    .buf_o(buf_q), .inc_o(inc_buf), .dec_o(dec_buf)
  );

  stage_flag_bank #(.N_STAGES(N_STAGES), .IDX_W(IDX_W)) u_flags (
    .clk_i, .rst_ni, .act_req_i, .act_idx_i, .deact_req_i, .deact_idx_i,
    .flags_o(stage_flags_o), .inc_o(inc_stg), .dec_o(dec_stg)
  );

  activity_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_buf_i(inc_buf), .dec_buf_i(dec_buf),
    .inc_stage_i(inc_stg), .dec_stage_i(dec_stg),
    .load_i, .load_val_i, .count_o
  );

  assign active_o   = |count_o;
  assign mismatch_o = int'(count_o) != ($countones(buf_q) + $countones(stage_flags_o));
endmodule

// File: rtl/activity_idle_tracker_chk.sv
module activity_idle_tracker_chk #(
  parameter int DEPTH    = 4,
  parameter int N_STAGES = 5,
  localparam int CNT_W   = $clog2(DEPTH + N_STAGES + 1),
  localparam int IDX_W   = $clog2(N_STAGES) + 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                record_i,
  input logic                advance_i,
  input logic                act_req_i,
  input logic [IDX_W-1:0]    act_idx_i,
  input logic                deact_req_i,
  input logic [IDX_W-1:0]    deact_idx_i,
  input logic                load_i,
  input logic [CNT_W-1:0]    count_o,
  input logic [N_STAGES-1:0] stage_flags_o,
  input logic                mismatch_o,
  input logic [DEPTH-1:0]    buf_q
);
  localparam logic [CNT_W-1:0] CMax = '1;

  p_record_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (record_i && !advance_i && !load_i && !act_req_i && !deact_req_i &&
     !buf_q[0] && count_o != CMax) |=> count_o == $past(count_o) + 1'b1);

  p_record_repeat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (record_i && !advance_i && !load_i && !act_req_i && !deact_req_i && buf_q[0])
    |=> $stable(count_o) && $stable(buf_q));

  p_adv_rec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && record_i) |=> buf_q[0]);

  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !record_i) |=> buf_q == ($past(buf_q) << 1));

  p_activate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_req_i && act_idx_i < IDX_W'(N_STAGES) && !deact_req_i)
    |=> stage_flags_o[$past(act_idx_i)]);

  p_idx_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_req_i && act_idx_i >= IDX_W'(N_STAGES) && !deact_req_i)
    |=> $stable(stage_flags_o));

  p_floor_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !load_i && !record_i && !act_req_i) |=> count_o == '0);

  p_mismatch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mismatch_o) |-> $past(load_i));
endmodule

bind activity_idle_tracker activity_idle_tracker_chk #(.DEPTH(DEPTH), .N_STAGES(N_STAGES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .record_i(record_i), .advance_i(advance_i),
  .act_req_i(act_req_i), .act_idx_i(act_idx_i), .deact_req_i(deact_req_i),
  .deact_idx_i(deact_idx_i), .load_i(load_i), .count_o(count_o),
  .stage_flags_o(stage_flags_o), .mismatch_o(mismatch_o), .buf_q(buf_q)
);

// File: tb/sim_activity_idle_tracker.sv
module sim_activity_idle_tracker;
  localparam int ClkPeriod = 10;
  localparam int DEPTH = 4;
  localparam int NST   = 5;
  localparam int CNT_W = $clog2(DEPTH + NST + 1);
  localparam int IDX_W = $clog2(NST) + 1;

  logic clk_i = 0, rst_ni = 0;
  logic record_i = 0, advance_i = 0, act_req_i = 0, deact_req_i = 0, load_i = 0;
  logic [IDX_W-1:0] act_idx_i = '0, deact_idx_i = '0;
  logic [CNT_W-1:0] load_val_i = '0;
  logic active_o, mismatch_o;
  logic [CNT_W-1:0] count_o;
  logic [NST-1:0] stage_flags_o;

  int n_chk = 0, n_fail = 0;

  always #(ClkPeriod/2) clk_i = ~clk_i;

  activity_idle_tracker #(.DEPTH(DEPTH), .N_STAGES(NST)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    record_i = 0; advance_i = 0; act_req_i = 0; deact_req_i = 0; load_i = 0;
  endtask

  // one clock edge, then sample 1 time unit later
  task automatic tick();
    @(posedge clk_i); #1;
    quiet();
  endtask

  task automatic check_state(string req, int cnt, int flags);
    chk({req, " count"}, int'(count_o), cnt);
    chk({req, " active"}, int'(active_o), int'(cnt != 0));
    chk({req, " flags"}, int'(stage_flags_o), flags);
  endtask

  task automatic t_reset();
    check_state("R1", 0, 0);
    chk("R1 mismatch", int'(mismatch_o), 0);
  endtask

  task automatic t_record_retire();
    record_i = 1; tick();
    check_state("R2 first record", 1, 0);
    record_i = 1; tick();
    check_state("R2 repeat record", 1, 0);
    for (int k = 1; k < DEPTH; k++) begin
      advance_i = 1; tick();
      check_state("R3 in flight", 1, 0);
    end
    advance_i = 1; tick();
    check_state("R3 retired R8", 0, 0);
  endtask

  task automatic t_adv_rec();
    record_i = 1; tick();
    check_state("R4 setup", 1, 0);
    advance_i = 1; record_i = 1; tick();
    check_state("R4 shift+record", 2, 0);
    for (int k = 1; k < DEPTH - 1; k++) begin
      advance_i = 1; tick();
      check_state("R4 both in flight", 2, 0);
    end
    advance_i = 1; tick();
    check_state("R4 older retired", 1, 0);
    advance_i = 1; tick();
    check_state("R4 newer retired", 0, 0);
  endtask

  task automatic t_stages();
    act_req_i = 1; act_idx_i = 2; tick();
    check_state("R5 activate", 1, 5'b00100);
    act_req_i = 1; act_idx_i = 2; tick();
    check_state("R5 re-activate", 1, 5'b00100);
    act_req_i = 1; act_idx_i = 2; deact_req_i = 1; deact_idx_i = 2; tick();
    check_state("R12 same stage cancel", 1, 5'b00100);
    act_req_i = 1; act_idx_i = 4; deact_req_i = 1; deact_idx_i = 2; tick();
    check_state("R12 swap stages", 1, 5'b10000);
    deact_req_i = 1; deact_idx_i = 1; tick();
    check_state("R6 deactivate inactive", 1, 5'b10000);
    deact_req_i = 1; deact_idx_i = 4; tick();
    check_state("R6 deactivate", 0, 0);
    chk("R11 consistent", int'(mismatch_o), 0);
  endtask

  task automatic t_range();
    act_req_i = 1; act_idx_i = 5; tick();
    check_state("R7 idx 5", 0, 0);
    act_req_i = 1; act_idx_i = 15; tick();
    check_state("R7 idx 15", 0, 0);
    act_req_i = 1; act_idx_i = 0; tick();
    deact_req_i = 1; deact_idx_i = 8; tick();
    check_state("R7 deact idx 8", 1, 5'b00001);
    deact_req_i = 1; deact_idx_i = 0; tick();
    check_state("R7 cleanup", 0, 0);
  endtask

  task automatic t_load_sat();
    load_i = 1; load_val_i = 7; tick();
    check_state("R9 preload", 7, 0);
    chk("R11 after preload", int'(mismatch_o), 1);
    load_i = 1; load_val_i = 0; record_i = 1; tick();
    check_state("R9 preload wins", 0, 0);
    chk("R11 mark vs zero", int'(mismatch_o), 1);
    for (int k = 0; k < DEPTH; k++) begin
      advance_i = 1; tick();
    end
    check_state("R10 floor", 0, 0);
    chk("R11 realigned", int'(mismatch_o), 0);
    load_i = 1; load_val_i = '1; act_req_i = 1; act_idx_i = 3; tick();
    check_state("R10 load max", 15, 5'b01000);
    record_i = 1; tick();
    check_state("R10 ceiling", 15, 5'b01000);
    load_i = 1; load_val_i = 0; deact_req_i = 1; deact_idx_i = 3;
    advance_i = 1; tick();
    for (int k = 0; k < DEPTH; k++) begin
      advance_i = 1; tick();
    end
    check_state("R9 cleanup", 0, 0);
    chk("R11 cleanup", int'(mismatch_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1;
    tick();
    t_reset();
    t_record_retire();
    t_adv_rec();
    t_stages();
    t_range();
    t_load_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule